// File: doc/BRIEF.md
# Procedure Call Frame Stack

This block keeps the call/return linkage of an instruction fetch unit in hardware. The topmost procedure frames live in a 128-entry general register file. A call needs no register copying. The return PC and the caller's frame base are pushed onto a small dedicated linkage stack. The new frame base is then placed so that the arguments the caller has already pushed become the callee's lowest locals. A return pops the linkage and restores the PC and frame base together in one cycle.

The block also tracks the register stack pointer and translates 4-bit frame-relative local indices into absolute register numbers. Spilling frames to memory is out of scope. When the linkage stack would overflow or underflow, or the stack pointer would leave the register file, the block only reports it and changes nothing.

The control is a three-state machine on the linkage stack occupancy:
- `LS_EMPTY`: no saved frames.
- `LS_PARTIAL`: some saved frames, but not all slots used.
- `LS_FULL`: all slots used.

The transitions are:
- *enter*: a call from `LS_EMPTY`.
- *fill*: a call that takes the last free slot.
- *drain*: a return that frees the last saved frame.
- *unfill*: a return from `LS_FULL`.
- *deepen*: a call within `LS_PARTIAL`.
- *shrink*: a return within `LS_PARTIAL`.
- *overflow*: a call in `LS_FULL`, which stays in `LS_FULL`.
- *underflow*: a return in `LS_EMPTY`, which stays in `LS_EMPTY`.

Top module: `fstk_frame_unit`

## Requirements
- R1: While reset is asserted, `pc_o`, `rl_o`, `sp_o` and `depth_o` are 0, and all three error flags are 0.
- R2: The op code on `op_i` is applied at a rising edge. A push (code 1) raises `sp_o` by one and a pop (code 2) lowers it by one. Both results are visible after that edge, and the frame base and linkage are left unchanged.
- R3: A push with `sp_o` at 127, or a pop with `sp_o` at 0, leaves `sp_o` unchanged. It sets `sp_err_o` for exactly the next cycle.
- R4: A call (code 3) that is accepted loads `pc_o` with `call_pc_i` and `rl_o` with (`sp_o` + 1 − `argc_i`) mod 128. It raises `depth_o` by one and leaves `sp_o` unchanged.
- R5: A call saves `ret_pc_i` and the old `rl_o`. A return (code 4) restores the most recently saved pair to `pc_o` and `rl_o` in one cycle, in last-in-first-out order, and lowers `depth_o` by one.
- R6: A call while `depth_o` is 8 sets `link_ovf_o` for exactly the next cycle. It changes no other output.
- R7: A return while `depth_o` is 0 sets `link_unf_o` for exactly the next cycle. It changes no other output.
- R8: `abs_reg_o` equals (`rl_o` + `idx_i`) mod 128 in the same cycle, including wrap past register 127.
- R9: After a call with argument count n ≥ 1, local index n−1 maps to the register that held the stack top before the call. The arguments become locals in place.
- R10: The op codes are 0 no-op, 1 push, 2 pop, 3 call and 4 return. Codes 5, 6 and 7 act as a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation code for this cycle |
| call_pc_i | input | 32 | Destination PC of a call |
| ret_pc_i | input | 32 | Return PC saved by a call |
| argc_i | input | 4 | Argument count from the callee's entry byte |
| idx_i | input | 4 | Frame-relative local index |
| pc_o | output | 32 | Current PC held by the unit |
| rl_o | output | 7 | Current frame base register |
| sp_o | output | 7 | Register stack pointer |
| depth_o | output | 4 | Number of saved linkage entries |
| abs_reg_o | output | 7 | Absolute register number for `idx_i` |
| link_ovf_o | output | 1 | Linkage stack overflow, one-cycle pulse |
| link_unf_o | output | 1 | Linkage stack underflow, one-cycle pulse |
| sp_err_o | output | 1 | Stack pointer saturation, one-cycle pulse |

## Verification
Every registered result (PC, frame base, stack pointer, depth and the three flags) is due one rising edge after the op that causes it. The register translation is combinational and is due in the same cycle as `idx_i`. The bench drives inputs at the falling edge and advances its behavioural model at the rising edge. It compares all outputs at the following falling edge, so each result is checked in the exact cycle it becomes due. Because the flags are compared on every cycle, each one is also confirmed to drop one cycle later.

// File: rtl/fstk_pkg.sv
package fstk_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4
    } fstk_op_e;

    typedef enum logic [1:0] {
        LS_EMPTY   = 2'd0,
        LS_PARTIAL = 2'd1,
        LS_FULL    = 2'd2
    } fstk_lstate_e;

endpackage

// File: rtl/fstk_link_ctrl.sv
module fstk_link_ctrl
    import fstk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             call_req,
    input  logic             ret_req,
    output logic             push_en,
    output logic             pop_en,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             unf_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam fstk_lstate_e AFTER_ENTER  = (DEPTH == 1) ? LS_FULL  : LS_PARTIAL;
    localparam fstk_lstate_e AFTER_UNFILL = (DEPTH == 1) ? LS_EMPTY : LS_PARTIAL;

    fstk_lstate_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q, unf_q, ovf_d, unf_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_EMPTY;
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ovf_q   <= ovf_d;
            unf_q   <= unf_d;
            if (push_en)
                cnt_q <= cnt_q + CNT_ONE;
            else if (pop_en)
                cnt_q <= cnt_q - CNT_ONE;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        push_en = 1'b0;
        pop_en  = 1'b0;
        ovf_d   = 1'b0;
        unf_d   = 1'b0;
        unique case (state_q)
            LS_EMPTY: begin
                if (call_req) begin          // enter
                    push_en = 1'b1;
                    state_d = AFTER_ENTER;
                end else if (ret_req) begin  // underflow
                    unf_d = 1'b1;
                end
            end
            LS_PARTIAL: begin
                if (call_req) begin          // deepen / fill
                    push_en = 1'b1;
                    if (cnt_q == CNT_LAST)
                        state_d = LS_FULL;
                end else if (ret_req) begin  // shrink / drain
                    pop_en = 1'b1;
                    if (cnt_q == CNT_ONE)
                        state_d = LS_EMPTY;
                end
            end
            LS_FULL: begin
                if (call_req) begin          // overflow
                    ovf_d = 1'b1;
                end else if (ret_req) begin  // unfill
                    pop_en  = 1'b1;
                    state_d = AFTER_UNFILL;
                end
            end
            default: state_d = LS_EMPTY;
        endcase
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;
    assign unf_o = unf_q;

    // R6
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> ($stable(cnt_q) && state_q == LS_FULL));

    // R7
    unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_q |-> ($stable(cnt_q) && cnt_q == '0));

    // R5
    link_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |=> (cnt_q == $past(cnt_q) - CNT_ONE));

endmodule

// File: rtl/fstk_link_lifo.sv
module fstk_link_lifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 39,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              push_en,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] top_data
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  wr_idx, rd_idx;

    assign wr_idx   = PTR_W'(cnt_i);
    assign rd_idx   = PTR_W'(cnt_i - CNT_W'(1));
    assign top_data = slot_q[rd_idx];

    always_ff @(posedge clk) begin
        if (push_en)
            slot_q[wr_idx] <= push_data;
    end

endmodule

// File: rtl/fstk_regmap.sv
module fstk_regmap #(
    parameter int RF_AW = 7,
    parameter int IDX_W = 4
) (
    input  logic [RF_AW-1:0] base_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [RF_AW-1:0] abs_o
);

    // The adder is RF_AW bits wide, so the sum wraps mod the register file size.
    assign abs_o = base_i + RF_AW'(idx_i);

endmodule

// File: rtl/fstk_frame_unit.sv
module fstk_frame_unit
    import fstk_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int RF_AW  = 7,
    parameter int IDX_W  = 4,
    parameter int ARGC_W = 4,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [PC_W-1:0]   call_pc_i,
    input  logic [PC_W-1:0]   ret_pc_i,
    input  logic [ARGC_W-1:0] argc_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [RF_AW-1:0]  rl_o,
    output logic [RF_AW-1:0]  sp_o,
    output logic [3:0]        depth_o,
    output logic [RF_AW-1:0]  abs_reg_o,
    output logic              link_ovf_o,
    output logic              link_unf_o,
    output logic              sp_err_o
);

    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int LINK_W = PC_W + RF_AW;
    localparam logic [RF_AW-1:0] SP_TOP = '1;
    localparam logic [RF_AW-1:0] ONE    = RF_AW'(1);

    logic push_op, pop_op, call_req, ret_req;
    logic push_en, pop_en;
    logic [CNT_W-1:0]  cnt;
    logic [LINK_W-1:0] top_link;
    logic [PC_W-1:0]   pc_q;
    logic [RF_AW-1:0]  rl_q, sp_q, rl_call;
    logic              sp_err_q;

    // R10: codes 5..7 fall into the default arm.
    always_comb begin
        push_op  = 1'b0;
        pop_op   = 1'b0;
        call_req = 1'b0;
        ret_req  = 1'b0;
        case (op_i)
            OP_PUSH: push_op  = 1'b1;
            OP_POP:  pop_op   = 1'b1;
            OP_CALL: call_req = 1'b1;
            OP_RET:  ret_req  = 1'b1;
            default: ;
        endcase
    end

    fstk_link_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .call_req (call_req),
        .ret_req  (ret_req),
        .push_en  (push_en),
        .pop_en   (pop_en),
        .cnt_o    (cnt),
        .ovf_o    (link_ovf_o),
        .unf_o    (link_unf_o)
    );

    fstk_link_lifo #(.DEPTH(DEPTH), .DATA_W(LINK_W), .CNT_W(CNT_W)) lifo_i (
        .clk       (clk),
        .push_en   (push_en),
        .cnt_i     (cnt),
        .push_data ({ret_pc_i, rl_q}),
        .top_data  (top_link)
    );

    fstk_regmap #(.RF_AW(RF_AW), .IDX_W(IDX_W)) map_i (
        .base_i (rl_q),
        .idx_i  (idx_i),
        .abs_o  (abs_reg_o)
    );

    // R4: the new base sits under the pushed arguments.
    assign rl_call = sp_q + ONE - RF_AW'(argc_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            rl_q <= '0;
        end else if (push_en) begin
            pc_q <= call_pc_i;
            rl_q <= rl_call;
        end else if (pop_en) begin
            pc_q <= top_link[LINK_W-1:RF_AW];
            rl_q <= top_link[RF_AW-1:0];
        end
    end

    // R2, R3
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q     <= '0;
            sp_err_q <= 1'b0;
        end else begin
            sp_err_q <= 1'b0;
            if (push_op) begin
                if (sp_q == SP_TOP) sp_err_q <= 1'b1;
                else                sp_q     <= sp_q + ONE;
            end else if (pop_op) begin
                if (sp_q == '0)     sp_err_q <= 1'b1;
                else                sp_q     <= sp_q - ONE;
            end
        end
    end

    assign pc_o     = pc_q;
    assign rl_o     = rl_q;
    assign sp_o     = sp_q;
    assign depth_o  = 4'(cnt);
    assign sp_err_o = sp_err_q;

    // R3
    sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_err_q |-> $stable(sp_q));

    // R4
    call_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !link_ovf_o && cnt != CNT_W'(DEPTH)) |=>
            (rl_q == RF_AW'($past(sp_q) + ONE - RF_AW'($past(argc_i)))
             && pc_q == $past(call_pc_i)));

    // R6
    ovf_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_ovf_o |-> ($stable(pc_q) && $stable(rl_q)));

    // R7
    unf_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_unf_o |-> ($stable(pc_q) && $stable(rl_q)));

endmodule

// File: tb/fstk_frame_unit_tb.sv
module fstk_frame_unit_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic [31:0] call_pc_i = '0;
    logic [31:0] ret_pc_i = '0;
    logic [3:0]  argc_i = '0;
    logic [3:0]  idx_i = '0;
    logic [31:0] pc_o;
    logic [6:0]  rl_o, sp_o, abs_reg_o;
    logic [3:0]  depth_o;
    logic        link_ovf_o, link_unf_o, sp_err_o;

    always #(CLK_P/2) clk = ~clk;

    fstk_frame_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .call_pc_i(call_pc_i),
        .ret_pc_i(ret_pc_i), .argc_i(argc_i), .idx_i(idx_i), .pc_o(pc_o),
        .rl_o(rl_o), .sp_o(sp_o), .depth_o(depth_o), .abs_reg_o(abs_reg_o),
        .link_ovf_o(link_ovf_o), .link_unf_o(link_unf_o), .sp_err_o(sp_err_o)
    );

    // behavioural model
    int unsigned m_pc, m_rl, m_sp;
    int unsigned q_pc[$];
    int unsigned q_rl[$];
    bit m_ovf, m_unf, m_err;
    int vectors = 0;
    int miscompares = 0;

    task automatic chk(string tag, int unsigned got, int unsigned exp);
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        vectors++;
        chk("R4/R5 pc", pc_o, m_pc);
        chk("R4/R5 rl", rl_o, m_rl);
        chk("R2 sp", sp_o, m_sp);
        chk("R5 depth", depth_o, q_pc.size());
        chk("R8 abs_reg", abs_reg_o, (m_rl + idx_i) & 127);
        chk("R6 ovf", link_ovf_o, m_ovf);
        chk("R7 unf", link_unf_o, m_unf);
        chk("R3 sp_err", sp_err_o, m_err);
    endtask

    task automatic model_reset();
        m_pc = 0; m_rl = 0; m_sp = 0;
        q_pc.delete(); q_rl.delete();
        m_ovf = 0; m_unf = 0; m_err = 0;
    endtask

    task automatic model_step(int unsigned op, int unsigned cpc, int unsigned rpc, int unsigned argc);
        m_ovf = 0; m_unf = 0; m_err = 0;
        case (op)
            1: if (m_sp == 127) m_err = 1; else m_sp++;
            2: if (m_sp == 0) m_err = 1; else m_sp--;
            3: if (q_pc.size() == 8) m_ovf = 1;
               else begin
                   q_pc.push_back(m_pc); q_rl.push_back(m_rl);
                   m_pc = cpc;
                   m_rl = (m_sp + 1 - argc) & 127;
                   q_pc[q_pc.size()-1] = rpc;
               end
            4: if (q_pc.size() == 0) m_unf = 1;
               else begin
                   m_pc = q_pc.pop_back();
                   m_rl = q_rl.pop_back();
               end
            default: ;
        endcase
    endtask

    // Called at a falling edge; returns at the next falling edge after compare.
    task automatic cycle(int unsigned op, int unsigned cpc, int unsigned rpc,
                         int unsigned argc, int unsigned idx);
        op_i = 3'(op); call_pc_i = cpc; ret_pc_i = rpc;
        argc_i = 4'(argc); idx_i = 4'(idx);
        @(posedge clk);
        model_step(op, cpc, rpc, argc);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int unsigned sp_before;
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        compare_all();
        rst_n = 1'b1;

        // R8: translation at base 0
        for (int i = 0; i < 16; i++) cycle(0, 0, 0, 0, i);

        // R2: pushes
        for (int i = 0; i < 5; i++) cycle(1, 0, 0, 0, 0);

        // R4 / R9: call with two arguments, index 1 maps to old stack top
        sp_before = m_sp;
        cycle(3, 32'h100, 32'h10, 2, 1);
        vectors++;
        chk("R9 arg in place", abs_reg_o, sp_before);

        // R6: fill the linkage stack, then overflow twice
        for (int i = 0; i < 7; i++) begin
            cycle(1, 0, 0, 0, 3);
            cycle(3, 32'h200 + i, 32'h20 + i, i % 4, i);
        end
        cycle(3, 32'hDEAD, 32'hBEEF, 1, 0);
        cycle(3, 32'hDEAD, 32'hBEEF, 1, 0);
        cycle(0, 0, 0, 0, 0);

        // R10: unused codes leave all state alone
        sp_before = m_sp;
        for (int c = 5; c < 8; c++) cycle(c, 32'h55, 32'h66, 3, 2);
        vectors++;
        chk("R10 unused code", sp_o, sp_before);

        // R5 / R7: unwind past empty
        for (int i = 0; i < 10; i++) cycle(4, 0, 0, 0, 15);

        // R3: pop below zero, then push beyond top
        while (m_sp != 0) cycle(2, 0, 0, 0, 0);
        cycle(2, 0, 0, 0, 0);
        cycle(2, 0, 0, 0, 0);
        for (int i = 0; i < 130; i++) cycle(1, 0, 0, 0, 0);

        // R4 / R8: base and index wrap past 127
        for (int i = 0; i < 124; i++) cycle(2, 0, 0, 0, 0);
        cycle(3, 32'h300, 32'h30, 15, 15);
        cycle(0, 0, 0, 0, 15);
        cycle(4, 0, 0, 0, 9);

        // mixed traffic
        for (int i = 0; i < 4000; i++)
            cycle($urandom_range(0, 7), $urandom, $urandom,
                  $urandom_range(0, 15), $urandom_range(0, 15));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule